// File: doc/BRIEF.md
# Prescaled Dual Timer Unit

This peripheral holds two independent down-counting timers, one meant as a real-time clock and one for general use. Each timer is a two-stage chain. A prescaler counts system clocks and sends a tick to a counter. The counter counts those ticks down. When the counter underflows, the timer sends a single-cycle interrupt request to an interrupt controller outside this block. With reload on, the timer repeats at a fixed period. With reload off, it stops after one pass.

Software uses a 32-bit register port addressed by byte offset. Each timer has a counter address that works both ways: a write stores the reload value, and a read returns the live count. Each timer's scaler value is write-only. One write-only control word enables, loads and sets reload for both timers. The register port has no data stream and no handshake. A write takes effect on the clock edge where `wr_en` is high, and `rd_data` follows `addr` combinationally, so there is nothing that can apply back-pressure.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset, both timers are disabled, with reload off and a stop flag that is clear. Both counter reads return 0, and both interrupt outputs are low.
- R2: A write to offset 0x80 (real-time timer) or 0x88 (general timer) stores the counter reload value and leaves the live count unchanged. A read of the same offset returns the live count, zero-extended.
- R3: A read of any offset other than 0x80 and 0x88 returns 0. This includes the scaler offsets 0x84 and 0x8C and the control offset 0x98. A write to an unused offset changes nothing.
- R4: The control word at 0x98 is laid out per timer. For the real-time timer, bit 0 is enable, bit 1 is load and bit 2 is reload. For the general timer, bits 8, 9 and 10 have the same roles. A written load bit copies that timer's scaler value and counter value into its live prescaler and counter on that same edge and clears its stop flag. The load bit is not stored.
- R5: While enabled, the prescaler counts down once per clock. On an edge where it is zero, it reloads from the scaler value and gives one tick. With scaler value S, ticks are S+1 clocks apart.
- R6: The counter decrements on each tick. A tick at count zero is an underflow, and the interrupt output is high for the one cycle after that edge. After a load with scaler S and count C, the first underflow comes (C+1)(S+1) edges after the load edge.
- R7: With reload on, the counter reloads its counter value at underflow. Interrupts then repeat every (C+1)(S+1) clocks.
- R8: With reload off, the counter stays at zero after underflow and raises no further interrupt until the next load.
- R9: A disabled timer holds its prescaler and its count and raises no interrupt. A load still works while the timer is disabled.
- R10: The two timers run independently. Writes and counting on one timer never change the other timer's count or its interrupts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the prescaler input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, taken on the rising edge |
| addr | input | 8 | Byte offset of the register access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| rtc_irq | output | 1 | One-cycle underflow pulse of the real-time timer |
| gpt_irq | output | 1 | One-cycle underflow pulse of the general timer |

## Verification
The hardest cases to reach are the exact underflow cycle and a timer that has stopped at zero. The only visible sign of either is a pulse that arrives, or does not arrive, a computed number of edges after a load. The bench records the edge on which each control write lands and derives every expected interrupt edge from (C+1)(S+1). It then lets one timer run with reload while the other counts through a single pass with reload off and stays silent. Every pulse is matched against a queue of predicted edges, so an early, late, missing or extra pulse is reported.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  localparam int NUM_TMR      = 2;
  localparam int TMR_RTC      = 0;
  localparam int TMR_GPT      = 1;
  // per-timer register window: counter at base, scaler at base+4
  localparam int OFS_CNT_BASE = 'h80;
  localparam int OFS_STRIDE   = 8;
  localparam int OFS_SCL_REL  = 4;
  localparam int OFS_CTRL     = 'h98;
  // control word: per-timer byte lane, bits inside a lane
  localparam int CTRL_LANE    = 8;
  localparam int CTRL_EN      = 0;
  localparam int CTRL_LOAD    = 1;
  localparam int CTRL_RLD     = 2;
endpackage

// File: rtl/dtt_prescaler.sv
module dtt_prescaler #(
  parameter int SCL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [SCL_W-1:0] prog_i,
  output logic             tick_o
);
  logic [SCL_W-1:0] scl_q;

  assign tick_o = en_i && !load_i && (scl_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)          scl_q <= '0;
    else if (load_i)     scl_q <= prog_i;
    else if (en_i) begin
      if (scl_q == '0)   scl_q <= prog_i;
      else               scl_q <= scl_q - SCL_W'(1);
    end
  end

  // R5
  scl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !load_i && scl_q != '0) |=> (scl_q == $past(scl_q) - SCL_W'(1)));

  // R9
  scl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !load_i) |=> $stable(scl_q));
endmodule

// File: rtl/dtt_counter.sv
module dtt_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic             rld_i,
  input  logic [CNT_W-1:0] prog_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             stop_q;
  logic             uflow;

  assign uflow = tick_i && !load_i && (cnt_q == '0) && !stop_q;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stop_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= uflow;
      if (load_i) begin
        cnt_q  <= prog_i;
        stop_q <= 1'b0;
      end else if (uflow) begin
        if (rld_i) cnt_q  <= prog_i;
        else       stop_q <= 1'b1;
      end else if (tick_i && cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  // R4
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(prog_i)));

  // R6
  irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(tick_i));

  // R8
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !load_i) |=> !irq_o);

  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dtt_regfile.sv
module dtt_regfile
  import dtt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SCL_W  = 16,
  parameter int CNT_W  = 24
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic [NUM_TMR-1:0][CNT_W-1:0]   live_cnt,
  output logic [DATA_W-1:0]               rd_data,
  output logic [NUM_TMR-1:0][SCL_W-1:0]   scl_prog,
  output logic [NUM_TMR-1:0][CNT_W-1:0]   cnt_prog,
  output logic [NUM_TMR-1:0]              en,
  output logic [NUM_TMR-1:0]              rld,
  output logic [NUM_TMR-1:0]              load
);
  logic ctrl_hit;
  logic unused_wr_bits;
  logic [NUM_TMR-1:0][DATA_W-1:0] rd_lane;

  assign ctrl_hit       = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign unused_wr_bits = ^wr_data;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    localparam int CNT_OFS = OFS_CNT_BASE + t * OFS_STRIDE;
    localparam int SCL_OFS = CNT_OFS + OFS_SCL_REL;
    localparam int LANE    = t * CTRL_LANE;

    assign load[t]    = ctrl_hit && wr_data[LANE + CTRL_LOAD];
    assign rd_lane[t] = (addr == ADDR_W'(CNT_OFS))
                        ? {{(DATA_W-CNT_W){1'b0}}, live_cnt[t]} : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        scl_prog[t] <= '0;
        cnt_prog[t] <= '0;
        en[t]       <= 1'b0;
        rld[t]      <= 1'b0;
      end else if (wr_en) begin
        if (addr == ADDR_W'(SCL_OFS)) scl_prog[t] <= wr_data[SCL_W-1:0];
        if (addr == ADDR_W'(CNT_OFS)) cnt_prog[t] <= wr_data[CNT_W-1:0];
        if (ctrl_hit) begin
          en[t]  <= wr_data[LANE + CTRL_EN];
          rld[t] <= wr_data[LANE + CTRL_RLD];
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int t = 0; t < NUM_TMR; t++) rd_data = rd_data | rd_lane[t];
  end
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter int SCL_W = 16,
  parameter int CNT_W = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        rtc_irq,
  output logic        gpt_irq
);
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic [NUM_TMR-1:0][SCL_W-1:0] scl_prog;
  logic [NUM_TMR-1:0][CNT_W-1:0] cnt_prog;
  logic [NUM_TMR-1:0][CNT_W-1:0] live_cnt;
  logic [NUM_TMR-1:0]            en, rld, load, tick, irq;

  dtt_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SCL_W(SCL_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .live_cnt(live_cnt), .rd_data(rd_data), .scl_prog(scl_prog),
    .cnt_prog(cnt_prog), .en(en), .rld(rld), .load(load)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_chan
    dtt_prescaler #(.SCL_W(SCL_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .en_i(en[t]), .load_i(load[t]),
      .prog_i(scl_prog[t]), .tick_o(tick[t])
    );
    dtt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick[t]), .load_i(load[t]),
      .rld_i(rld[t]), .prog_i(cnt_prog[t]), .cnt_o(live_cnt[t]), .irq_o(irq[t])
    );
  end

  assign rtc_irq = irq[TMR_RTC];
  assign gpt_irq = irq[TMR_GPT];

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!rtc_irq && !gpt_irq));
endmodule

// File: tb/dual_tick_timer_bench.sv
module dual_tick_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rtc_irq, gpt_irq;

  dual_tick_timer u_dual_tick_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .rtc_irq(rtc_irq), .gpt_irq(gpt_irq)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  int q_rtc[$];
  int q_gpt[$];

  task automatic check(input string req, input longint act, input longint exp,
                       input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output int e_n);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    e_n = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input longint exp, input string req,
                    input string what);
    addr = a;
    #1;
    check(req, rd_data, exp, what);
  endtask

  // monitor: every pulse must match the next predicted edge
  int exp_e;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rtc_irq) begin
        if (q_rtc.size() == 0) check("R6", cyc, -1, "unexpected rtc pulse");
        else begin exp_e = q_rtc.pop_front(); check("R7", cyc, exp_e, "rtc pulse edge"); end
      end
      if (gpt_irq) begin
        if (q_gpt.size() == 0) check("R8", cyc, -1, "unexpected gpt pulse");
        else begin exp_e = q_gpt.pop_front(); check("R6", cyc, exp_e, "gpt pulse edge"); end
      end
    end
  end

  initial begin
    #(4 * 20000);
    check("R1", 0, 1, "watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int k, g, d, h, d2, tmp, held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h80, 0, "R1", "rtc count after reset");
    rd(8'h88, 0, "R1", "gpt count after reset");
    check("R1", {rtc_irq, gpt_irq}, 0, "irq after reset");

    wr(8'h84, 2, tmp);
    wr(8'h80, 3, tmp);
    rd(8'h84, 0, "R3", "rtc scaler readback");
    rd(8'h80, 0, "R2", "live rtc untouched by program write");
    wr(8'h8C, 0, tmp);
    wr(8'h88, 4, tmp);
    rd(8'h8C, 0, "R3", "gpt scaler readback");
    rd(8'h98, 0, "R3", "control readback");

    // R4: load rtc only while disabled
    wr(8'h98, 32'h2, tmp);
    rd(8'h80, 3, "R4", "rtc loaded");
    rd(8'h88, 0, "R4", "gpt not loaded");
    repeat (10) @(negedge clk);
    rd(8'h80, 3, "R9", "disabled rtc holds");

    // rtc: enable+load+reload, S=2 C=3, period 12
    wr(8'h98, 32'h7, k);
    for (int n = 1; n <= 6; n++) q_rtc.push_back(k + 12 * n);
    while (cyc < k + 5) @(negedge clk);
    rd(8'h80, 2, "R5", "rtc count after one tick");

    // gpt one shot S=0 C=4; rtc keeps running
    wr(8'h98, 32'h305, g);
    q_gpt.push_back(g + 5);
    while (cyc < g + 8) @(negedge clk);
    rd(8'h88, 0, "R8", "gpt stays at zero");

    while (cyc < k + 73) @(negedge clk);
    wr(8'h98, 32'h0, d);
    held = 3 - (d - (k + 72)) / 3;
    rd(8'h80, held, "R9", "rtc count at disable");
    repeat (10) @(negedge clk);
    rd(8'h80, held, "R9", "rtc count held");

    // gpt reload S=1 C=1, period 4, re-armed by load
    wr(8'h8C, 1, tmp);
    wr(8'h88, 1, tmp);
    wr(8'h98, 32'h700, h);
    q_gpt.push_back(h + 4);
    q_gpt.push_back(h + 8);
    q_gpt.push_back(h + 12);
    while (cyc < h + 13) @(negedge clk);
    wr(8'h98, 32'h0, d2);
    rd(8'h80, held, "R10", "rtc unaffected by gpt");

    wr(8'hA0, 32'hFFFF_FFFF, tmp);
    rd(8'hA0, 0, "R3", "unused offset read");
    rd(8'h80, held, "R3", "unused write no effect");

    repeat (20) @(negedge clk);
    check("R7", q_rtc.size(), 0, "rtc pulses outstanding");
    check("R6", q_gpt.size(), 0, "gpt pulses outstanding");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule